// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Unit

This block holds the privileged control state of a small RISC-V hart that supports machine and user modes. It keeps the current privilege level, the status fields (MIE, MPIE, MPP), the saved exception PC, the cause and trap-value registers, and the trap vector base. The pipeline presents one of three requests. A trap request carries a cause code, an interrupt/exception flag, the PC of the current instruction, the PC of the next instruction and a trap value. An MRET strobe asks for a return. A CSR access reads or writes one of the five registers.

The unit decides combinationally, in the same cycle, which event is taken. It drives `redirect_valid` and `redirect_pc` so the fetch stage can jump at once. All register updates for that event happen on the next clock edge. The privilege level is a two-state machine with states `PRIV_U` and `PRIV_M`. It has three transitions. **Trap-enter** goes from either state to `PRIV_M`. **Return** goes from `PRIV_M` to the state held in MPP. **Hold** applies on every other cycle. The event chosen each cycle is one of `EV_TRAP`, `EV_MRET`, `EV_CSR` or `EV_NONE`, in that priority order.

CSR addresses are the standard machine-mode ones: mstatus 0x300, mtvec 0x305, mepc 0x341, mcause 0x342, mtval 0x343. Only direct (non-vectored) trap dispatch is provided.

Top module: `mtrap_unit`

## Requirements
- R1: An accepted trap sets MPIE to the old MIE, clears MIE, sets MPP to the privilege in force before the trap (00 user, 11 machine) and makes the privilege machine. All of these take effect on one clock edge.
- R2: On an accepted trap, mepc takes the next-instruction PC for an interrupt and the current PC for an exception. Bits 1:0 of mepc are always zero.
- R3: In the cycle a trap is accepted, `redirect_valid` is 1 and `redirect_pc` equals the mtvec value held before that edge.
- R4: On an accepted trap, mcause bit 31 takes the interrupt flag and its low bits take the cause code, zero-extended. Standard codes are 3, 7 and 11 for machine software, timer and external interrupts. mtval takes the trap value.
- R5: An MRET in machine mode redirects to mepc in the same cycle. On the edge, the privilege becomes MPP, MIE takes MPIE, MPIE becomes 1 and MPP becomes user (00).
- R6: An MRET strobe while in user mode is ignored. There is no redirect and no state change.
- R7: An interrupt is accepted only when MIE is 1 or the hart is in user mode. An exception is always accepted. A refused interrupt causes no redirect and changes no state.
- R8: When a trap is accepted in the same cycle as an MRET, the trap is taken and the MRET is dropped.
- R9: In mstatus, MIE sits at bit 3, MPIE at bit 7 and MPP at bits 12:11, and every other bit reads 0. mtvec bits 1:0 are forced to zero on write.
- R10: A CSR access to an unknown address, or any CSR access made in user mode, raises `csr_illegal`, reads 0 and writes nothing.
- R11: A write of 01 or 10 to the MPP field leaves MPP unchanged.
- R12: A CSR write in the same cycle as an accepted trap is dropped.
- R13: After reset the privilege is machine, mstatus reads 0, mtvec equals RESET_VEC (default 0x100), and mepc, mcause and mtval read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Trap request |
| trap_is_irq | input | 1 | 1 = interrupt, 0 = exception |
| trap_code | input | CODE_W | Cause code |
| trap_pc | input | XLEN | PC of the current instruction |
| trap_next_pc | input | XLEN | PC of the next instruction |
| trap_val | input | XLEN | Trap value for mtval |
| mret_req | input | 1 | MRET strobe |
| csr_en | input | 1 | CSR access valid |
| csr_we | input | 1 | CSR write enable |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (0 when illegal) |
| csr_illegal | output | 1 | Access refused |
| redirect_valid | output | 1 | Fetch redirect this cycle |
| redirect_pc | output | XLEN | Redirect target |
| priv_o | output | 2 | Current privilege (00 user, 11 machine) |

## Verification
Traps are swept over every combination of starting privilege, MIE value and interrupt/exception flag, with three cause codes each. Odd PCs are used so that the saved-PC selection and the forced-zero low bits can be told apart. The interrupt/exception split shows whether the next PC or the current PC is saved. The privilege and MIE combinations show the acceptance rule, including masked interrupts in machine mode and interrupts always taken from user mode. Directed cases cover:
- a trap colliding with an MRET;
- a trap colliding with a CSR write;
- a machine-to-machine return;
- unsupported MPP write values;
- user-mode and unknown-address CSR accesses, followed by a read-back of the state they could have touched.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_TRAP,
        EV_MRET,
        EV_CSR
    } event_e;

    localparam logic [11:0] ADDR_MSTATUS = 12'h300;
    localparam logic [11:0] ADDR_MTVEC   = 12'h305;
    localparam logic [11:0] ADDR_MEPC    = 12'h341;
    localparam logic [11:0] ADDR_MCAUSE  = 12'h342;
    localparam logic [11:0] ADDR_MTVAL   = 12'h343;

    localparam int BIT_MIE    = 3;
    localparam int BIT_MPIE   = 7;
    localparam int BIT_MPP_LO = 11;

endpackage

// File: rtl/mtrap_arbiter.sv
module mtrap_arbiter
    import mtrap_pkg::*;
(
    input  logic   trap_req,
    input  logic   trap_is_irq,
    input  logic   mret_req,
    input  logic   csr_en,
    input  logic   csr_we,
    input  logic   csr_known,
    input  priv_e  priv,
    input  logic   mie,
    output event_e ev,
    output logic   csr_illegal
);

    logic irq_open;
    logic trap_ok;
    logic mret_ok;
    logic csr_ok;

    always_comb begin
        // user mode always lets interrupts through
        irq_open    = mie || (priv == PRIV_U);
        trap_ok     = trap_req && (!trap_is_irq || irq_open);
        mret_ok     = mret_req && (priv == PRIV_M);
        csr_ok      = csr_en && csr_we && csr_known && (priv == PRIV_M);
        csr_illegal = csr_en && (!csr_known || (priv != PRIV_M));
        if (trap_ok)      ev = EV_TRAP;
        else if (mret_ok) ev = EV_MRET;
        else if (csr_ok)  ev = EV_CSR;
        else              ev = EV_NONE;
    end

endmodule

// File: rtl/mtrap_csr_file.sv
module mtrap_csr_file
    import mtrap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              CODE_W    = 5,
    parameter logic [XLEN-1:0] RESET_VEC = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  event_e            ev,
    input  priv_e             priv,
    input  logic              trap_is_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_next_pc,
    input  logic [XLEN-1:0]   trap_val,
    input  logic [11:0]       csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic              mie,
    output logic              mpie,
    output priv_e             mpp,
    output logic [XLEN-1:0]   mepc,
    output logic [XLEN-1:0]   mtvec,
    output logic [XLEN-1:0]   rdata_raw,
    output logic              csr_known
);

    localparam int              PAD_W    = XLEN - 1 - CODE_W;
    localparam logic [XLEN-1:0] ALIGN_MK = {{(XLEN-2){1'b1}}, 2'b00};

    logic [XLEN-1:0] mcause;
    logic [XLEN-1:0] mtval;
    logic [XLEN-1:0] save_pc;
    logic [1:0]      wr_mpp;

    always_comb begin
        save_pc = trap_is_irq ? trap_next_pc : trap_pc;
        wr_mpp  = csr_wdata[BIT_MPP_LO +: 2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mie    <= 1'b0;
            mpie   <= 1'b0;
            mpp    <= PRIV_U;
            mepc   <= '0;
            mcause <= '0;
            mtval  <= '0;
            mtvec  <= RESET_VEC & ALIGN_MK;
        end else begin
            unique case (ev)
                EV_TRAP: begin
                    mpie   <= mie;
                    mie    <= 1'b0;
                    mpp    <= priv;
                    mepc   <= save_pc & ALIGN_MK;
                    mcause <= {trap_is_irq, {PAD_W{1'b0}}, trap_code};
                    mtval  <= trap_val;
                end
                EV_MRET: begin
                    mie  <= mpie;
                    mpie <= 1'b1;
                    mpp  <= PRIV_U;
                end
                EV_CSR: begin
                    case (csr_addr)
                        ADDR_MSTATUS: begin
                            mie  <= csr_wdata[BIT_MIE];
                            mpie <= csr_wdata[BIT_MPIE];
                            if (wr_mpp == 2'b00 || wr_mpp == 2'b11)
                                mpp <= priv_e'(wr_mpp);
                        end
                        ADDR_MTVEC:  mtvec  <= csr_wdata & ALIGN_MK;
                        ADDR_MEPC:   mepc   <= csr_wdata & ALIGN_MK;
                        ADDR_MCAUSE: mcause <= csr_wdata;
                        ADDR_MTVAL:  mtval  <= csr_wdata;
                        default: ;
                    endcase
                end
                EV_NONE: ;
            endcase
        end
    end

    always_comb begin
        rdata_raw = '0;
        csr_known = 1'b1;
        case (csr_addr)
            ADDR_MSTATUS: begin
                rdata_raw[BIT_MIE]          = mie;
                rdata_raw[BIT_MPIE]         = mpie;
                rdata_raw[BIT_MPP_LO +: 2]  = mpp;
            end
            ADDR_MTVEC:  rdata_raw = mtvec;
            ADDR_MEPC:   rdata_raw = mepc;
            ADDR_MCAUSE: rdata_raw = mcause;
            ADDR_MTVAL:  rdata_raw = mtval;
            default:     csr_known = 1'b0;
        endcase
    end

    // R1: status stacking on trap entry
    a_r1_status_stack: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_TRAP) |=> (!mie && mpie == $past(mie) && mpp == $past(priv)));

    // R5: status unstacking on return
    a_r5_status_unstack: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_MRET) |=> (mpie && mpp == PRIV_U && mie == $past(mpie)));

    // R4: interrupt flag lands in the top bit of mcause
    a_r4_cause_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_TRAP) |=> (mcause[XLEN-1] == $past(trap_is_irq)));

    // R11: MPP only ever holds a supported mode
    a_r11_mpp_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (mpp == PRIV_U) || (mpp == PRIV_M));

endmodule

// File: rtl/mtrap_unit.sv
module mtrap_unit
    import mtrap_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              CODE_W    = 5,
    parameter logic [XLEN-1:0] RESET_VEC = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic              trap_is_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_next_pc,
    input  logic [XLEN-1:0]   trap_val,
    input  logic              mret_req,
    input  logic              csr_en,
    input  logic              csr_we,
    input  logic [11:0]       csr_addr,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_illegal,
    output logic              redirect_valid,
    output logic [XLEN-1:0]   redirect_pc,
    output logic [1:0]        priv_o
);

    priv_e           priv_q;
    priv_e           priv_d;
    event_e          ev;
    logic            mie;
    logic            mpie;
    priv_e           mpp;
    logic [XLEN-1:0] mepc;
    logic [XLEN-1:0] mtvec;
    logic [XLEN-1:0] rdata_raw;
    logic            csr_known;

    mtrap_arbiter u_arb (
        .trap_req    (trap_req),
        .trap_is_irq (trap_is_irq),
        .mret_req    (mret_req),
        .csr_en      (csr_en),
        .csr_we      (csr_we),
        .csr_known   (csr_known),
        .priv        (priv_q),
        .mie         (mie),
        .ev          (ev),
        .csr_illegal (csr_illegal)
    );

    mtrap_csr_file #(
        .XLEN      (XLEN),
        .CODE_W    (CODE_W),
        .RESET_VEC (RESET_VEC)
    ) u_csr (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev           (ev),
        .priv         (priv_q),
        .trap_is_irq  (trap_is_irq),
        .trap_code    (trap_code),
        .trap_pc      (trap_pc),
        .trap_next_pc (trap_next_pc),
        .trap_val     (trap_val),
        .csr_addr     (csr_addr),
        .csr_wdata    (csr_wdata),
        .mie          (mie),
        .mpie         (mpie),
        .mpp          (mpp),
        .mepc         (mepc),
        .mtvec        (mtvec),
        .rdata_raw    (rdata_raw),
        .csr_known    (csr_known)
    );

    // privilege state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) priv_q <= PRIV_M;
        else        priv_q <= priv_d;
    end

    // privilege transitions: trap-enter, return, hold
    always_comb begin
        priv_d = priv_q;
        unique case (ev)
            EV_TRAP:        priv_d = PRIV_M;
            EV_MRET:        priv_d = mpp;
            EV_CSR, EV_NONE: ;
        endcase
    end

    // outputs
    always_comb begin
        redirect_valid = 1'b0;
        redirect_pc    = '0;
        unique case (ev)
            EV_TRAP: begin
                redirect_valid = 1'b1;
                redirect_pc    = mtvec;
            end
            EV_MRET: begin
                redirect_valid = 1'b1;
                redirect_pc    = mepc;
            end
            EV_CSR, EV_NONE: ;
        endcase
        priv_o    = priv_q;
        csr_rdata = (csr_en && !csr_illegal) ? rdata_raw : '0;
    end

    // R1: any taken trap leaves the hart in machine mode
    a_r1_enter_machine: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_TRAP) |=> (priv_q == PRIV_M));

    // R7: masked interrupt in machine mode is never taken
    a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_is_irq && !mie && priv_q == PRIV_M) |-> (ev != EV_TRAP));

    // R6: return strobe in user mode has no effect
    a_r6_user_mret: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_q == PRIV_U && mret_req && !trap_req) |=> (priv_q == PRIV_U));

    // R10: user-mode CSR access refused and reads zero
    a_r10_user_csr: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_en && priv_q == PRIV_U) |-> (csr_illegal && csr_rdata == '0));

    // R8: a taken trap excludes a return in the same cycle
    a_r8_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_is_irq && mret_req) |-> (ev == EV_TRAP));

endmodule

// File: tb/mtrap_unit_tb.sv
module mtrap_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_MSTATUS = 12'h300;
    localparam logic [11:0] A_MTVEC   = 12'h305;
    localparam logic [11:0] A_MEPC    = 12'h341;
    localparam logic [11:0] A_MCAUSE  = 12'h342;
    localparam logic [11:0] A_MTVAL   = 12'h343;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic        trap_is_irq = 1'b0;
    logic [4:0]  trap_code = '0;
    logic [31:0] trap_pc = '0;
    logic [31:0] trap_next_pc = '0;
    logic [31:0] trap_val = '0;
    logic        mret_req = 1'b0;
    logic        csr_en = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        csr_illegal;
    logic        redirect_valid;
    logic [31:0] redirect_pc;
    logic [1:0]  priv_o;

    int n_checks = 0;
    int n_fail = 0;
    logic        s_rv;
    logic [31:0] s_rp;
    logic        s_ill;
    logic [31:0] s_rd;

    // bench model of architectural state
    logic [1:0]  m_priv;
    logic        m_mie;
    logic        m_mpie;
    logic [1:0]  m_mpp;
    logic [31:0] m_mepc;
    logic [31:0] m_mcause;
    logic [31:0] m_mtval;
    logic [31:0] m_mtvec;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtrap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_is_irq(trap_is_irq),
        .trap_code(trap_code), .trap_pc(trap_pc), .trap_next_pc(trap_next_pc),
        .trap_val(trap_val), .mret_req(mret_req), .csr_en(csr_en), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc), .priv_o(priv_o)
    );

    function automatic logic [31:0] ms(input logic ie, input logic pie, input logic [1:0] pp);
        return (32'(pp) << 11) | (32'(pie) << 7) | (32'(ie) << 3);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        trap_req = 1'b0; mret_req = 1'b0; csr_en = 1'b0; csr_we = 1'b0;
    endtask

    // one cycle: drive at negedge, sample combinational outputs, cross the edge
    task automatic fire(input logic tr, input logic irq, input logic [4:0] code,
                        input logic [31:0] pc, input logic [31:0] val, input logic mr,
                        input logic cw, input logic [11:0] ca, input logic [31:0] cd);
        @(negedge clk);
        trap_req = tr; trap_is_irq = irq; trap_code = code;
        trap_pc = pc; trap_next_pc = pc + 32'd4; trap_val = val;
        mret_req = mr; csr_en = cw; csr_we = cw; csr_addr = ca; csr_wdata = cd;
        #1;
        s_rv = redirect_valid; s_rp = redirect_pc; s_ill = csr_illegal; s_rd = csr_rdata;
        @(posedge clk);
        #1;
    endtask

    task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
        fire(0, 0, 0, 0, 0, 0, 1, a, d);
    endtask

    task automatic csr_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        idle();
        csr_en = 1'b1; csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic verify(input string ctx);
        logic [31:0] d;
        check({"R1 priv ", ctx}, 32'(priv_o), 32'(m_priv));
        csr_read(A_MSTATUS, d); check({"R1 mstatus ", ctx}, d, ms(m_mie, m_mpie, m_mpp));
        csr_read(A_MEPC, d);    check({"R2 mepc ", ctx}, d, m_mepc);
        csr_read(A_MCAUSE, d);  check({"R4 mcause ", ctx}, d, m_mcause);
        csr_read(A_MTVAL, d);   check({"R4 mtval ", ctx}, d, m_mtval);
        csr_read(A_MTVEC, d);   check({"R9 mtvec ", ctx}, d, m_mtvec);
    endtask

    task automatic model_trap(input logic irq, input logic [4:0] code,
                              input logic [31:0] pc, input logic [31:0] val);
        m_mpie = m_mie; m_mie = 1'b0; m_mpp = m_priv; m_priv = 2'b11;
        m_mepc = (irq ? pc + 32'd4 : pc) & 32'hFFFF_FFFC;
        m_mcause = {irq, 26'd0, code};
        m_mtval = val;
    endtask

    // reach user mode with a chosen MIE value
    task automatic go_user(input logic ie, input logic [31:0] ret_pc);
        csr_write(A_MSTATUS, ms(0, ie, 2'b00));
        csr_write(A_MEPC, ret_pc);
        fire(0, 0, 0, 0, 0, 1, 0, 0, 0);
        check("R5 mret redirect valid", 32'(s_rv), 32'd1);
        check("R5 mret redirect pc", s_rp, ret_pc);
        m_mie = ie; m_mpie = 1'b1; m_mpp = 2'b00; m_priv = 2'b00; m_mepc = ret_pc;
        check("R5 priv after mret", 32'(priv_o), 32'd0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [4:0]  code;
        logic [31:0] tvec;
        logic [31:0] pc;
        logic [31:0] val;
        logic        acc;
        int          it;

        m_priv = 2'b11; m_mie = 0; m_mpie = 0; m_mpp = 2'b00;
        m_mepc = 0; m_mcause = 0; m_mtval = 0; m_mtvec = 32'h100;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R13 reset state
        verify("R13 reset");

        // sweep: start privilege x MIE x interrupt flag x three codes
        for (int sp = 0; sp < 2; sp++) begin
            for (int ie = 0; ie < 2; ie++) begin
                for (int irq = 0; irq < 2; irq++) begin
                    for (int k = 0; k < 3; k++) begin
                        it = ((sp * 2 + ie) * 2 + irq) * 3 + k;
                        if (irq == 1) code = (k == 0) ? 5'd3 : (k == 1) ? 5'd7 : 5'd11;
                        else          code = (k == 0) ? 5'd2 : (k == 1) ? 5'd5 : 5'd13;
                        tvec = 32'h1000 + 32'(it) * 32'd16;
                        csr_write(A_MTVEC, tvec | 32'd3);
                        m_mtvec = tvec;
                        if (sp == 0) begin
                            go_user(ie[0], 32'h2000 + 32'(it) * 32'd4);
                        end else begin
                            csr_write(A_MSTATUS, ms(ie[0], 0, 2'b11));
                            m_mie = ie[0]; m_mpie = 1'b0; m_mpp = 2'b11;
                        end
                        pc  = 32'h4000 + 32'(it) * 32'd8 + 32'd1;
                        val = 32'hABC0_0000 + 32'(it);
                        acc = (irq == 0) || m_mie || (m_priv == 2'b00);
                        fire(1, irq[0], code, pc, val, 0, 0, 0, 0);
                        check("R7 accept", 32'(s_rv), 32'(acc));
                        if (acc) begin
                            check("R3 redirect to mtvec", s_rp, m_mtvec);
                            model_trap(irq[0], code, pc, val);
                        end
                        verify("sweep");
                    end
                end
            end
        end

        // R8 trap and MRET together: trap wins
        csr_write(A_MSTATUS, ms(1, 1, 2'b11));
        m_mie = 1; m_mpie = 1; m_mpp = 2'b11;
        fire(1, 0, 5'd2, 32'h6000, 32'h55, 1, 0, 0, 0);
        check("R8 redirect pc", s_rp, m_mtvec);
        model_trap(0, 5'd2, 32'h6000, 32'h55);
        verify("R8");

        // R5 return from machine to machine
        csr_write(A_MEPC, 32'h3000);
        csr_write(A_MSTATUS, ms(0, 1, 2'b11));
        fire(0, 0, 0, 0, 0, 1, 0, 0, 0);
        check("R5 redirect valid", 32'(s_rv), 32'd1);
        check("R5 redirect pc", s_rp, 32'h3000);
        m_mepc = 32'h3000; m_mie = 1; m_mpie = 1; m_mpp = 2'b00; m_priv = 2'b11;
        verify("R5 M to M");

        // R11 unsupported MPP values
        csr_write(A_MSTATUS, ms(0, 0, 2'b01));
        csr_read(A_MSTATUS, d); check("R11 mpp 01 ignored", d, ms(0, 0, 2'b00));
        csr_write(A_MSTATUS, ms(0, 0, 2'b11));
        csr_write(A_MSTATUS, ms(0, 0, 2'b10));
        csr_read(A_MSTATUS, d); check("R11 mpp 10 ignored", d, ms(0, 0, 2'b11));
        m_mie = 0; m_mpie = 0; m_mpp = 2'b11;

        // R12 trap and CSR write together: write dropped
        fire(1, 0, 5'd4, 32'h7000, 32'h77, 0, 1, A_MTVAL, 32'hDEAD_BEEF);
        model_trap(0, 5'd4, 32'h7000, 32'h77);
        verify("R12");

        // R10 unknown address in machine mode
        fire(0, 0, 0, 0, 0, 0, 1, 12'h7C0, 32'h1234);
        check("R10 unknown addr illegal", 32'(s_ill), 32'd1);
        check("R10 unknown addr reads 0", s_rd, 32'd0);

        // R10 and R6 in user mode
        go_user(0, 32'h5000);
        fire(0, 0, 0, 0, 0, 0, 1, A_MTVEC, 32'h9999_0000);
        check("R10 user csr illegal", 32'(s_ill), 32'd1);
        check("R10 user csr reads 0", s_rd, 32'd0);
        fire(0, 0, 0, 0, 0, 1, 0, 0, 0);
        check("R6 user mret no redirect", 32'(s_rv), 32'd0);
        check("R6 user mret priv held", 32'(priv_o), 32'd0);
        fire(1, 0, 5'd8, 32'h5000, 32'h0, 0, 0, 0, 0);
        check("R3 trap from user", s_rp, m_mtvec);
        model_trap(0, 5'd8, 32'h5000, 32'h0);
        verify("R10 R6 after user");

        idle();
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule